// File: doc/BRIEF.md
# Stereo Digital Volume Ramp with Soft Mute

This block computes the effective attenuation code for the left and right channels of a playback path. Each channel has an 8-bit programmed level. Codes 0 to 254 give 0 dB down to -127 dB in 0.5 dB steps, and code 255 is full mute. The outputs never jump. On each step the effective code moves one code toward its target. A step fires on every N-th sample strobe, where N is chosen by a 2-bit ramp-time field. A downstream multiplier turns the code into a gain. That multiplier is outside this block.

A soft-mute input retargets both channels to the mute code, so the output fades out. Clearing soft mute retargets the channels to their programmed levels, so the output fades back in. If soft mute is cancelled partway through a fade, the ramp turns around at the code it has reached. A link input makes the left level drive both channels. The right level input is still present, but while link is set it has no effect.

Top module: `softmute_vol`

## Requirements
- R1: When reset is asserted, both effective codes become 255 (mute) and the strobe divider is cleared.
- R2: An effective code changes by at most one per clock. When it changes, it moves toward its channel's target. Code k means k*0.5 dB of attenuation for k in 0..254, and 255 means mute.
- R3: A step fires on the clock edge of a sample strobe once the divider has counted N strobes, where N = 2^(DIV_LOG2_MIN + ramp_sel_i). With the default this is N = 1, 2, 4 or 8. Outputs change only on edges where smp_stb_i is 1.
- R4: When link_i is 1, both channels target att_l_i and att_r_i has no effect on either output.
- R5: When link_i is 0, the left channel targets att_l_i and the right channel targets att_r_i.
- R6: When smute_i is 1, both channels target code 255 and ramp to it.
- R7: When smute_i returns to 0, each channel ramps back to its programmed level, one code per step.
- R8: When soft mute is cancelled mid-ramp, the next step moves one code back toward the programmed level, starting from the current code.
- R9: When soft mute is off, a change of programmed level is reached by one-code steps and never by a jump.
- R10: An effective code that equals its target holds its value.
- R11: If ramp_sel_i is lowered while the divider count is at or above the new limit, the next strobe fires a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_stb_i | input | 1 | One-clock pulse per audio sample |
| att_l_i | input | 8 | Left programmed attenuation code |
| att_r_i | input | 8 | Right programmed attenuation code |
| link_i | input | 1 | 1: the left level drives both channels |
| smute_i | input | 1 | 1: ramp both channels to mute |
| ramp_sel_i | input | 2 | Strobes per step, as a power of two |
| eff_l_o | output | 8 | Left effective attenuation code |
| eff_r_o | output | 8 | Right effective attenuation code |

## Verification
The hardest case to reach is a soft-mute cancel that lands partway through a fade. It needs a slow ramp setting and a cancel timed after only some of the steps. The bench starts from a settled level, requests mute for a fixed number of strobes, and then cancels. It then waits for the first change and checks that this change is one code back toward the level. The divider corner is handled in a similar way. The bench runs at the slowest ramp setting for a few strobes and then switches to the fastest, so the count is already past the new limit when the switch happens.

// File: rtl/vol_pkg.sv
package vol_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/vol_step_div.sv
module vol_step_div #(
  parameter int SEL_W        = 2,
  parameter int DIV_LOG2_MIN = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int CNT_W = DIV_LOG2_MIN + (1 << SEL_W);
  localparam int LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim;

  assign lim    = (LIM_W'(1) << (LIM_W'(sel_i) + LIM_W'(DIV_LOG2_MIN))) - LIM_W'(1);
  // >= so a shortened period fires on the next strobe
  assign step_o = stb_i && ({1'b0, cnt_q} >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else if (stb_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_STEP_ONLY_ON_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(cnt_q)) else $error("cnt moved without strobe"); // R3
endmodule

// File: rtl/vol_tgt_sel.sv
module vol_tgt_sel #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] att_l_i,
  input  logic [CODE_W-1:0] att_r_i,
  input  logic              link_i,
  input  logic              smute_i,
  output logic [CODE_W-1:0] tgt_l_o,
  output logic [CODE_W-1:0] tgt_r_o
);
  localparam logic [CODE_W-1:0] MUTE_CODE = '1;

  logic [CODE_W-1:0] lvl [2];

  always_comb begin
    lvl[0] = att_l_i;
    lvl[1] = link_i ? att_l_i : att_r_i;
  end

  assign tgt_l_o = smute_i ? MUTE_CODE : lvl[0];
  assign tgt_r_o = smute_i ? MUTE_CODE : lvl[1];
endmodule

// File: rtl/vol_ramp_chan.sv
module vol_ramp_chan #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic [CODE_W-1:0] eff_o
);
  import vol_pkg::*;

  localparam logic [CODE_W-1:0] MUTE_CODE = '1;

  logic [CODE_W-1:0] eff_q;
  ramp_dir_e         dir;

  always_comb begin
    if (eff_q < tgt_i)      dir = DIR_UP;
    else if (eff_q > tgt_i) dir = DIR_DOWN;
    else                    dir = DIR_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_q <= MUTE_CODE;
    else if (step_i) begin
      unique case (dir)
        DIR_UP:   eff_q <= eff_q + CODE_W'(1);
        DIR_DOWN: eff_q <= eff_q - CODE_W'(1);
        default:  eff_q <= eff_q;
      endcase
    end
  end

  assign eff_o = eff_q;

  AST_ONE_CODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((eff_q == $past(eff_q)) || (eff_q == $past(eff_q) + CODE_W'(1)) ||
                (eff_q == $past(eff_q) - CODE_W'(1)))) else $error("jump"); // R2
  AST_HOLD_AT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_q == tgt_i) |=> $stable(eff_q)) else $error("left target"); // R10
  AST_STEP_TOWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (eff_q != tgt_i)) |=> (eff_q != $past(eff_q))) else $error("stalled"); // R2
  AST_NO_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(eff_q)) else $error("moved without step"); // R3
endmodule

// File: rtl/softmute_vol.sv
module softmute_vol #(
  parameter int CODE_W       = 8,
  parameter int SEL_W        = 2,
  parameter int DIV_LOG2_MIN = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic [CODE_W-1:0] att_l_i,
  input  logic [CODE_W-1:0] att_r_i,
  input  logic              link_i,
  input  logic              smute_i,
  input  logic [SEL_W-1:0]  ramp_sel_i,
  output logic [CODE_W-1:0] eff_l_o,
  output logic [CODE_W-1:0] eff_r_o
);
  localparam int N_CH = 2;

  logic              step;
  logic [CODE_W-1:0] tgt [N_CH];
  logic [CODE_W-1:0] eff [N_CH];

  vol_step_div #(.SEL_W(SEL_W), .DIV_LOG2_MIN(DIV_LOG2_MIN)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (smp_stb_i),
    .sel_i  (ramp_sel_i),
    .step_o (step)
  );

  vol_tgt_sel #(.CODE_W(CODE_W)) u_tgt (
    .att_l_i (att_l_i),
    .att_r_i (att_r_i),
    .link_i  (link_i),
    .smute_i (smute_i),
    .tgt_l_o (tgt[0]),
    .tgt_r_o (tgt[1])
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    vol_ramp_chan #(.CODE_W(CODE_W)) u_ramp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step),
      .tgt_i  (tgt[ch]),
      .eff_o  (eff[ch])
    );
  end

  assign eff_l_o = eff[0];
  assign eff_r_o = eff[1];

  AST_LINK_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i && (eff_l_o == eff_r_o)) |=> (eff_l_o == eff_r_o)) else $error("link split"); // R4
  AST_STB_GATES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_stb_i |=> ($stable(eff_l_o) && $stable(eff_r_o))) else $error("moved off strobe"); // R3
  AST_MUTE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smute_i && (&eff_l_o)) |=> (&eff_l_o)) else $error("left mute"); // R6
endmodule

// File: tb/softmute_vol_tb_top.sv
module softmute_vol_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_stb_i = 1'b0;
  logic [7:0] att_l_i = 8'd0;
  logic [7:0] att_r_i = 8'd0;
  logic       link_i = 1'b1;
  logic       smute_i = 1'b0;
  logic [1:0] ramp_sel_i = 2'd0;
  logic [7:0] eff_l_o, eff_r_o;

  always #10 clk_i = ~clk_i;

  softmute_vol dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_stb_i(smp_stb_i),
    .att_l_i(att_l_i), .att_r_i(att_r_i), .link_i(link_i),
    .smute_i(smute_i), .ramp_sel_i(ramp_sel_i),
    .eff_l_o(eff_l_o), .eff_r_o(eff_r_o)
  );

  int n_cmp = 0, n_bad = 0;
  int m_cnt = 0, m_l = 255, m_r = 255;
  int stb_per = 1, phase = 0;
  string cur_req = "R1";

  function automatic int toward(int v, int t);
    if (v < t) return v + 1;
    if (v > t) return v - 1;
    return v;
  endfunction

  // behavioural reference: strobe divider plus two targets
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_l = 255; m_r = 255;
    end else if (smp_stb_i) begin
      int lim, tl, tr;
      lim = (1 << ramp_sel_i) - 1;
      if (m_cnt >= lim) begin
        m_cnt = 0;
        tl = smute_i ? 255 : int'(att_l_i);
        tr = smute_i ? 255 : (link_i ? int'(att_l_i) : int'(att_r_i));
        m_l = toward(m_l, tl);
        m_r = toward(m_r, tr);
      end else m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    chk({cur_req, " left"}, int'(eff_l_o), m_l);
    chk({cur_req, " right"}, int'(eff_r_o), m_r);
    smp_stb_i = (stb_per <= 1) || ((phase % stb_per) == 0);
    phase++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int v;
    cur_req = "R1";
    run(3);
    chk("R1 reset left", int'(eff_l_o), 255);
    chk("R1 reset right", int'(eff_r_o), 255);
    rst_ni = 1'b1;

    cur_req = "R2 R9";
    run(300);
    chk("R9 left settled", int'(eff_l_o), 0);
    chk("R9 right settled", int'(eff_r_o), 0);

    cur_req = "R4";
    att_r_i = 8'd100;
    run(20);
    chk("R4 right ignores att_r", int'(eff_r_o), 0);

    cur_req = "R5";
    link_i = 1'b0; att_l_i = 8'd10; att_r_i = 8'd40;
    run(100);
    chk("R5 left", int'(eff_l_o), 10);
    chk("R5 right", int'(eff_r_o), 40);

    cur_req = "R3";
    ramp_sel_i = 2'd2; stb_per = 2; att_l_i = 8'd20;
    run(40);
    run(400);
    chk("R3 slow ramp left", int'(eff_l_o), 20);

    cur_req = "R6 R10";
    ramp_sel_i = 2'd0; stb_per = 1; smute_i = 1'b1;
    run(300);
    chk("R6 left muted", int'(eff_l_o), 255);
    chk("R6 right muted", int'(eff_r_o), 255);
    run(20);
    chk("R10 mute held", int'(eff_l_o), 255);

    cur_req = "R7";
    smute_i = 1'b0;
    run(300);
    chk("R7 left restored", int'(eff_l_o), 20);
    chk("R7 right restored", int'(eff_r_o), 40);

    cur_req = "R8";
    ramp_sel_i = 2'd1; smute_i = 1'b1;
    run(20);
    v = int'(eff_l_o);
    smute_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (int'(eff_l_o) != v) break;
    end
    chk("R8 reversal step", int'(eff_l_o), v - 1);
    run(200);
    chk("R8 back at level", int'(eff_l_o), 20);

    cur_req = "R11";
    ramp_sel_i = 2'd3; att_l_i = 8'd60;
    run(6);
    ramp_sel_i = 2'd0;
    run(3);
    run(100);
    chk("R11 left", int'(eff_l_o), 60);

    cur_req = "R4";
    link_i = 1'b1; att_l_i = 8'd50; att_r_i = 8'd200;
    run(100);
    chk("R4 linked left", int'(eff_l_o), 50);
    chk("R4 linked right", int'(eff_r_o), 50);

    cur_req = "R1";
    rst_ni = 1'b0;
    run(2);
    chk("R1 mid reset", int'(eff_l_o), 255);
    rst_ni = 1'b1;
    run(5);
    finish_run();
  end
endmodule